// File: doc/BRIEF.md
# Activity-Adaptive Scan Shift Clock Controller

This block paces the shift phase of a scan test. It watches the bits being loaded into a scan chain and picks the shift rate for each step. A monitor register takes a copy of every scan-in bit. The block counts how many neighbouring bit pairs change value across the incoming bit and the monitor contents. Few changes mean low switching power in the chain, so the next shift can come sooner. Many changes mean the next shift must wait longer.

The shift rate is produced as a one-cycle enable pulse on a fast reference clock. The pulse repeats every R reference cycles, and R is one of M divide ratios (1 through M). After reset, after a capture phase, or after a new load is announced, the block keeps the slowest ratio until the monitor register is full of fresh bits. From then on the ratio comes from the quiet-pair count.

Top module: `adaptive_scan_clk`

## Requirements
- R1: While reset is asserted (synchronous, active low), the shift pulse is low and the ratio output is M. The monitor register is cleared, so the toggle count equals the value of the incoming bit.
- R2: The toggle count is the number of value changes along the sequence made of the incoming bit followed by the N monitor bits, newest first. Its range is 0..N. Each shift pulse moves the incoming bit into the newest monitor position.
- R3: While shifting is enabled, the shift pulse is high for exactly one reference cycle. It then stays low for R-1 cycles, where R is the ratio output. The first pulse after enable rises comes R cycles later.
- R4: The ratio output changes only in the cycle after a shift pulse, or when shifting is disabled.
- R5: The first N shift pulses after reset, after enable rises, or after a load strobe each select ratio M. This holds the slowest rate until the monitor register holds N fresh bits.
- R6: Once the monitor register is full, each pulse selects the next ratio from the quiet count q = N - toggles. For N=8 and M=4: q of 0 or 1 gives ratio 4, q of 2 or 3 gives 3, q of 4 or 5 gives 2, and q of 6 to 8 gives 1.
- R7: While the scan enable is low, no shift pulse appears. The ratio returns to M and the fill count is cleared. The monitor register keeps its contents.
- R8: A load strobe clears the fill count. If it comes together with a shift pulse, that pulse selects ratio M. If it comes between pulses, the current period still runs out at its own ratio.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast reference clock |
| rst_n | input | 1 | Synchronous reset, active low |
| scan_enable | input | 1 | High during shift, low during capture |
| scan_load_start | input | 1 | One-cycle strobe marking the start of a new load |
| scan_bit_copy | input | 1 | Copy of the bit entering the scan chain |
| shift_pulse | output | 1 | One-cycle scan shift enable |
| rate_div | output | $clog2(M+1) | Current divide ratio, 1..M |
| toggle_cnt | output | $clog2(N)+1 | Current toggle count, 0..N |

## Verification
The bench drives several bit streams, each aimed at a different part of the ratio table:
- Constant zeros and long runs of equal bits land in the fastest band.
- Two-bit pairs land exactly on a band edge (4 quiet pairs).
- A period-three pattern lands in the second-slowest band.
- Strict alternation keeps the block at the slowest rate, so a wrong mapping or band edge shows up as a pulse at the wrong cycle.

Enable drops and load strobes, some of them landing on a pulse, test the fill hold and the rule that a period is never cut short. A long random stream with random capture gaps runs the whole path against a reference model that is compared on every cycle.

// File: rtl/asc_pkg.sv
package asc_pkg;
  // Maps a quiet-pair count to a divide ratio: M equal bands over 0..N,
  // lower-inclusive, the quietest band clipped to the last one.
  function automatic int unsigned ratio_from_quiet(int unsigned quiet,
                                                   int unsigned n,
                                                   int unsigned m);
    int unsigned band;
    band = (quiet * m) / n;
    if (band > m - 1) band = m - 1;
    return m - band;
  endfunction
endpackage

// File: rtl/asc_activity_mon.sv
module asc_activity_mon #(
  parameter int N  = 8,
  parameter int CW = $clog2(N) + 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          shift_fire,
  input  logic          bit_in,
  output logic [CW-1:0] toggles
);
  logic [N-1:0] mon_q;
  logic [N-1:0] edge_w;

  always_ff @(posedge clk) begin
    if (!rst_n)          mon_q <= '0;
    else if (shift_fire) mon_q <= {mon_q[N-2:0], bit_in};
  end

  assign edge_w[0] = bit_in ^ mon_q[0];
  for (genvar g = 1; g < N; g++) begin : g_pair
    assign edge_w[g] = mon_q[g-1] ^ mon_q[g];
  end

  function automatic logic [CW-1:0] ones(input logic [N-1:0] v);
    logic [CW-1:0] acc;
    acc = '0;
    for (int i = 0; i < N; i++) acc = acc + CW'(v[i]);
    return acc;
  endfunction

  assign toggles = ones(edge_w);

  AST_TOGGLE_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    toggles <= CW'(N)); // R2
endmodule

// File: rtl/asc_rate_select.sv
module asc_rate_select #(
  parameter int N  = 8,
  parameter int M  = 4,
  parameter int CW = $clog2(N) + 1,
  parameter int RW = $clog2(M + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          scan_enable,
  input  logic          load_start,
  input  logic          shift_fire,
  input  logic [CW-1:0] toggles,
  output logic [RW-1:0] next_ratio
);
  localparam int FW = $clog2(N + 1);

  logic [FW-1:0] fill_q;
  logic          filled;
  int unsigned   quiet_w;

  always_ff @(posedge clk) begin
    if (!rst_n)                         fill_q <= '0;
    else if (!scan_enable || load_start) fill_q <= '0;
    else if (shift_fire && !filled)     fill_q <= fill_q + FW'(1);
  end

  assign filled  = (fill_q == FW'(N));
  assign quiet_w = N - 32'(toggles);

  always_comb begin
    if (filled && !load_start)
      next_ratio = RW'(asc_pkg::ratio_from_quiet(quiet_w, N, M));
    else
      next_ratio = RW'(M);
  end

  AST_FILL_SLOW: assert property (@(posedge clk) disable iff (!rst_n)
    (shift_fire && !filled) |-> next_ratio == RW'(M)); // R5
  AST_STROBE_SLOW: assert property (@(posedge clk) disable iff (!rst_n)
    (shift_fire && load_start) |-> next_ratio == RW'(M)); // R8
  AST_NEXT_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    shift_fire |-> (next_ratio >= RW'(1) && next_ratio <= RW'(M))); // R6
endmodule

// File: rtl/asc_shift_divider.sv
module asc_shift_divider #(
  parameter int M  = 4,
  parameter int RW = $clog2(M + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          scan_enable,
  input  logic [RW-1:0] next_ratio,
  output logic          shift_fire,
  output logic [RW-1:0] ratio_q
);
  logic [RW-1:0] ph_q;

  assign shift_fire = scan_enable && (ph_q == ratio_q - RW'(1));

  always_ff @(posedge clk) begin
    if (!rst_n || !scan_enable) begin
      ph_q    <= '0;
      ratio_q <= RW'(M);
    end else if (shift_fire) begin
      ph_q    <= '0;
      ratio_q <= next_ratio;
    end else begin
      ph_q    <= ph_q + RW'(1);
    end
  end

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !scan_enable |-> !shift_fire); // R7
  AST_HOLD_BETWEEN: assert property (@(posedge clk) disable iff (!rst_n)
    (scan_enable && !shift_fire) |=> $stable(ratio_q)); // R4
  AST_PULSE_GAP: assert property (@(posedge clk) disable iff (!rst_n)
    shift_fire |=> (!shift_fire || ratio_q == RW'(1))); // R3
  AST_RATIO_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    ratio_q >= RW'(1) && ratio_q <= RW'(M)); // R6
endmodule

// File: rtl/adaptive_scan_clk.sv
module adaptive_scan_clk #(
  parameter  int N  = 8,
  parameter  int M  = 4,
  localparam int CW = $clog2(N) + 1,
  localparam int RW = $clog2(M + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          scan_enable,
  input  logic          scan_load_start,
  input  logic          scan_bit_copy,
  output logic          shift_pulse,
  output logic [RW-1:0] rate_div,
  output logic [CW-1:0] toggle_cnt
);
  logic          shift_fire;
  logic [CW-1:0] toggles;
  logic [RW-1:0] next_ratio;
  logic [RW-1:0] ratio_q;

  asc_activity_mon #(.N(N), .CW(CW)) u_mon (
    .clk(clk), .rst_n(rst_n), .shift_fire(shift_fire),
    .bit_in(scan_bit_copy), .toggles(toggles));

  asc_rate_select #(.N(N), .M(M), .CW(CW), .RW(RW)) u_sel (
    .clk(clk), .rst_n(rst_n), .scan_enable(scan_enable),
    .load_start(scan_load_start), .shift_fire(shift_fire),
    .toggles(toggles), .next_ratio(next_ratio));

  asc_shift_divider #(.M(M), .RW(RW)) u_div (
    .clk(clk), .rst_n(rst_n), .scan_enable(scan_enable),
    .next_ratio(next_ratio), .shift_fire(shift_fire), .ratio_q(ratio_q));

  assign shift_pulse = shift_fire;
  assign rate_div    = ratio_q;
  assign toggle_cnt  = toggles;

  AST_RESET_SLOW: assert property (@(posedge clk)
    !rst_n |=> (rate_div == RW'(M))); // R1
endmodule

// File: tb/adaptive_scan_clk_tb.sv
module adaptive_scan_clk_tb;
  localparam int N = 8;
  localparam int M = 4;

  logic clk = 0, rst_n = 0, en = 0, ld = 0, sbit = 0;
  logic       pulse;
  logic [2:0] ratio;
  logic [3:0] tcnt;

  always #2.5 clk = ~clk;

  adaptive_scan_clk #(.N(N), .M(M)) u_dut (
    .clk(clk), .rst_n(rst_n), .scan_enable(en), .scan_load_start(ld),
    .scan_bit_copy(sbit), .shift_pulse(pulse), .rate_div(ratio),
    .toggle_cnt(tcnt));

  int total = 0, bad = 0;
  int m_ph = 0, m_cur = M, m_fill = 0;
  bit m_reg[N];
  int mode = 0, kshift = 0;
  bit cur_bit = 0;
  bit finished = 0;
  string tag = "R1";
  bit prev_en = 0, prev_pulse = 0;
  int prev_ratio = M;

  function automatic int exp_count();
    int t = 0;
    bit prev = sbit;
    for (int i = 0; i < N; i++) begin
      if (m_reg[i] != prev) t++;
      prev = m_reg[i];
    end
    return t;
  endfunction

  function automatic int quiet_to_div(int q);
    case (q)
      0, 1:    return 4;
      2, 3:    return 3;
      4, 5:    return 2;
      default: return 1;
    endcase
  endfunction

  function automatic bit pick_bit(int md, int k);
    case (md)
      0: return 1'b0;
      1: return k[0];
      2: return k[1];
      3: return k[2];
      5: return (k % 8) == 0;
      6: return (k % 3) == 0;
      default: return 1'($urandom % 2);
    endcase
  endfunction

  task automatic check(string what, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s %s: actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  task automatic cycle(bit e, bit l);
    bit ep;
    int cnt;
    @(negedge clk);
    en = e; ld = l; sbit = cur_bit;
    #1;
    ep  = en && (m_ph == m_cur - 1);
    cnt = exp_count();
    check("pulse", pulse, ep);
    check("ratio", ratio, m_cur);
    check("toggle count", tcnt, cnt);
    if (prev_en && !prev_pulse && int'(ratio) != prev_ratio) begin
      total++; bad++;
      $display("FAIL R4 ratio moved between pulses: actual=%0d expected=%0d",
               ratio, prev_ratio);
    end
    prev_en = en; prev_pulse = pulse; prev_ratio = ratio;
    if (!en) begin
      m_ph = 0; m_fill = 0; m_cur = M;
    end else if (ep) begin
      m_cur = (ld || m_fill < N) ? M : quiet_to_div(N - cnt);
      for (int i = N - 1; i > 0; i--) m_reg[i] = m_reg[i-1];
      m_reg[0] = sbit;
      m_ph = 0;
      m_fill = ld ? 0 : (m_fill < N ? m_fill + 1 : N);
      kshift++;
      cur_bit = pick_bit(mode, kshift);
    end else begin
      m_ph++;
      if (ld) m_fill = 0;
    end
  endtask

  task automatic run(int md, int n, string t);
    mode = md; tag = t;
    cur_bit = pick_bit(mode, kshift);
    for (int i = 0; i < n; i++) cycle(1'b1, 1'b0);
  endtask

  initial begin
    for (int i = 0; i < N; i++) m_reg[i] = 0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    tag = "R1";
    check("reset pulse", pulse, 0);
    check("reset ratio", ratio, M);
    check("reset toggle count", tcnt, 0);
    sbit = 1; #1;
    check("reset toggle count with bit 1", tcnt, 1);
    sbit = 0;
    rst_n = 1;

    tag = "R7";
    for (int i = 0; i < 5; i++) cycle(1'b0, 1'b0);
    run(2, 150, "R2 R6 pairs");
    run(0, 80, "R6 zeros");
    run(1, 150, "R3 R6 alternate");
    tag = "R7";
    for (int i = 0; i < 6; i++) cycle(1'b0, 1'b0);
    run(3, 120, "R5 after enable");
    mode = 6; tag = "R8";
    for (int i = 0; i < 140; i++) cycle(1'b1, (i % 7) == 3);
    run(5, 100, "R6 sparse");
    mode = 4; tag = "R2 R3 R5 R8 random";
    for (int i = 0; i < 500; i++)
      cycle(($urandom % 40) != 0, ($urandom % 60) == 0);
    finished = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      bad++;
      $display("FAIL R3 watchdog: actual=hung expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule